// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached parallel I/O peripheral with three 8-bit ports, A, B and C. Port C is treated as two independent 4-bit halves, so four direction groups exist in total. A CPU reaches the block through an 8-bit data bus with a select, read and write strobes and a 2-bit register address. The address picks one of the three port data registers or the control register.

A control write has two meanings, chosen by its top bit. With the top bit set, it is a mode definition: it fixes the direction of port A, port B and each port C half, and it clears every output latch. With the top bit clear, it sets or clears exactly one port C line and leaves the other seven alone. Output ports drive the last value written until another write changes it. Input ports are never latched: a read returns whatever is on the pins while the read is active. Each pin has its own output enable, so the surrounding pad logic can build tri-state lines from it.

Top module: `pport_unit`

## Requirements
- R1: During and right after synchronous reset, every port is an input: all output enables are 0, all output latches are 0, and the read-data enable is 0.
- R2: Address 0 selects port A, 1 port B, 2 port C and 3 the control register. A data write changes only the latch of the addressed port. A read of address 3 returns 8'h00.
- R3: A control write with bit 7 = 1 is a mode definition. Bit 4 sets the port A direction, bit 3 the port C upper half (lines 7..4), bit 1 port B and bit 0 the port C lower half (lines 3..0), where 1 means input. Bits 6, 5 and 2 must be 0. An output group drives all its enables at 1; an input group drives all its enables at 0.
- R4: Every mode definition clears all three output latches to 0, whatever the new directions are.
- R5: A control write with bit 7 = 0 sets port C line number bits[3:1] to the value of bit 0. The other seven port C latch bits do not change.
- R6: Output latches and directions keep their values in every cycle with no committed write.
- R7: A read of port A or port B configured as input returns the live pin value present during the read.
- R8: A read of port A or port B configured as output returns its latch.
- R9: A read of port C returns, for each half, the latch if that half is an output and the live pins if it is an input. The two halves take their directions independently.
- R10: Accesses need the select. A write strobe without select changes nothing. The read-data enable is 1 only while both select and read are high, and the read data is 8'h00 otherwise.
- R11: A write commits on the clock edge at which select and write are both high. Its effect is visible at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data from the CPU |
| bus_rdata | output | 8 | Read data to the CPU |
| bus_rdata_oe | output | 1 | Read-data bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
The assertions assume that mode definitions carry 0 in bits 6, 5 and 2, and that a single write strobe is held for exactly one clock so that each write commits once. They also assume that pin inputs are already synchronous to the clock when read. The stimulus builds every mode word from four random direction bits with the mode fields forced to zero. It drives each bus access for a single cycle between falling edges and changes the pin values only at falling edges, so reads of live pins always see settled values.

// File: rtl/pport_pkg.sv
// Package: shared types and field positions for the parallel port interface.
// Assumes an 8-bit CPU bus and 8-bit ports; port C splits into two halves.
package pport_pkg;
    localparam int PORT_W   = 8;
    localparam int HALF_W   = PORT_W / 2;
    localparam int IDX_W    = $clog2(PORT_W);

    // Control word bit positions (behavioural: the decoder depends on them)
    localparam int CW_KIND   = 7;
    localparam int CW_A_DIR  = 4;
    localparam int CW_CU_DIR = 3;
    localparam int CW_B_DIR  = 1;
    localparam int CW_CL_DIR = 0;
    localparam int CW_VAL    = 0;
    localparam int CW_IDX_LO = 1;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } pport_sel_e;

    // Direction flags, 1 = input
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } pport_dir_t;
endpackage

// File: rtl/pport_ctrl.sv
// Module: control-word decoder. Holds the direction register and turns a
// control write into either a mode definition (with latch clear) or a
// one-hot port C bit update. Assumes mode fields are written as zero.
module pport_ctrl
    import pport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic                cw_kind,
    input  logic                cw_a_dir,
    input  logic                cw_cu_dir,
    input  logic                cw_b_dir,
    input  logic                cw_cl_dir,
    input  logic [IDX_W-1:0]    cw_idx,
    input  logic                cw_val,
    output pport_dir_t          dir_q,
    output logic                mode_clr,
    output logic [PORT_W-1:0]   sr_mask,
    output logic                sr_val
);
    logic sr_en;

    // Split the control write into its two meanings
    always_comb begin
        mode_clr = ctrl_wr && cw_kind;
        sr_en    = ctrl_wr && !cw_kind;
        sr_val   = cw_val;
    end

    // One-hot mask for the selected port C line
    always_comb begin
        sr_mask = '0;
        if (sr_en) sr_mask[cw_idx] = 1'b1;
    end

    // Direction register: all inputs after reset, reloaded on mode definition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
        end else if (mode_clr) begin
            dir_q <= '{a_in: cw_a_dir, cu_in: cw_cu_dir,
                       b_in: cw_b_dir, cl_in: cw_cl_dir};
        end
    end
endmodule

// File: rtl/pport_lane.sv
// Module: one direction group of W pins. Keeps an output latch updated
// under a bit mask, drives per-pin enables from its direction, and gives
// the read value (latch when output, live pins when input).
module pport_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] wr_data,
    input  logic         dir_in,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_data
);
    logic [W-1:0] latch_q;

    // Output latch: cleared on reset or mode definition, masked update otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || clr) latch_q <= '0;
        else               latch_q <= (latch_q & ~wr_mask) | (wr_data & wr_mask);
    end

    // Pin drive and read-back selection
    always_comb begin
        pin_out = latch_q;
        pin_oe  = {W{!dir_in}};
        rd_data = dir_in ? pin_in : latch_q;
    end
endmodule

// File: rtl/pport_unit.sv
// Module: top of the parallel port interface. Decodes bus accesses,
// routes writes to the port lanes and the control decoder, and muxes read
// data. Assumes bus strobes synchronous to clk; a write commits on every
// edge where select and write are both high.
module pport_unit
    import pport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    localparam int NHALF = PORT_W / HALF_W;

    pport_sel_e        sel;
    logic              wr_a, wr_b, wr_c, wr_ctrl;
    pport_dir_t        dir_q;
    logic              mode_clr;
    logic [PORT_W-1:0] sr_mask;
    logic              sr_val;
    logic [PORT_W-1:0] c_mask, c_data;
    logic [PORT_W-1:0] rd_a, rd_b, rd_c;
    logic [NHALF-1:0]  c_dir;

    // Address decode of committed writes
    always_comb begin
        sel     = pport_sel_e'(bus_addr);
        wr_a    = bus_sel && bus_wr && (sel == SEL_A);
        wr_b    = bus_sel && bus_wr && (sel == SEL_B);
        wr_c    = bus_sel && bus_wr && (sel == SEL_C);
        wr_ctrl = bus_sel && bus_wr && (sel == SEL_CTRL);
    end

    pport_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_ctrl),
        .cw_kind   (bus_wdata[CW_KIND]),
        .cw_a_dir  (bus_wdata[CW_A_DIR]),
        .cw_cu_dir (bus_wdata[CW_CU_DIR]),
        .cw_b_dir  (bus_wdata[CW_B_DIR]),
        .cw_cl_dir (bus_wdata[CW_CL_DIR]),
        .cw_idx    (bus_wdata[CW_IDX_LO +: IDX_W]),
        .cw_val    (bus_wdata[CW_VAL]),
        .dir_q     (dir_q),
        .mode_clr  (mode_clr),
        .sr_mask   (sr_mask),
        .sr_val    (sr_val)
    );

    pport_lane #(.W(PORT_W)) u_lane_a (
        .clk (clk), .rst_n (rst_n), .clr (mode_clr),
        .wr_mask (wr_a ? '1 : '0), .wr_data (bus_wdata),
        .dir_in (dir_q.a_in), .pin_in (pa_in),
        .pin_out (pa_out), .pin_oe (pa_oe), .rd_data (rd_a)
    );

    pport_lane #(.W(PORT_W)) u_lane_b (
        .clk (clk), .rst_n (rst_n), .clr (mode_clr),
        .wr_mask (wr_b ? '1 : '0), .wr_data (bus_wdata),
        .dir_in (dir_q.b_in), .pin_in (pb_in),
        .pin_out (pb_out), .pin_oe (pb_oe), .rd_data (rd_b)
    );

    // Port C update source: full data write or single-bit set/reset
    always_comb begin
        c_mask = wr_c ? '1 : sr_mask;
        c_data = wr_c ? bus_wdata : {PORT_W{sr_val}};
        c_dir  = {dir_q.cu_in, dir_q.cl_in};
    end

    // Port C halves, each with its own direction
    for (genvar h = 0; h < NHALF; h++) begin : g_c_half
        pport_lane #(.W(HALF_W)) u_lane_c (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (mode_clr),
            .wr_mask (c_mask[h*HALF_W +: HALF_W]),
            .wr_data (c_data[h*HALF_W +: HALF_W]),
            .dir_in  (c_dir[h]),
            .pin_in  (pc_in[h*HALF_W +: HALF_W]),
            .pin_out (pc_out[h*HALF_W +: HALF_W]),
            .pin_oe  (pc_oe[h*HALF_W +: HALF_W]),
            .rd_data (rd_c[h*HALF_W +: HALF_W])
        );
    end

    // Read data mux, driven only while a read is active
    always_comb begin
        bus_rdata_oe = bus_sel && bus_rd;
        bus_rdata    = '0;
        if (bus_rdata_oe) begin
            unique case (sel)
                SEL_A:    bus_rdata = rd_a;
                SEL_B:    bus_rdata = rd_b;
                SEL_C:    bus_rdata = rd_c;
                SEL_CTRL: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pport_unit_checker.sv
// Module: assertion checker for pport_unit, attached by bind. Assumes one
// clock per write strobe and mode fields written as zero.
module pport_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       bus_rdata_oe,
    input logic [7:0] pa_in,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_in,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_in,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    logic wr_any, wr_mode, wr_bit;

    // Classify the current bus access
    always_comb begin
        wr_any  = bus_sel && bus_wr;
        wr_mode = wr_any && (bus_addr == 2'd3) && bus_wdata[7];
        wr_bit  = wr_any && (bus_addr == 2'd3) && !bus_wdata[7];
    end

    // R4: a mode definition leaves all latches at zero
    assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    // R5: set/reset touches exactly one port C bit
    assert_bit_setreset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bit |=> (pc_out[$past(bus_wdata[3:1])] == $past(bus_wdata[0])) &&
                   (((pc_out ^ $past(pc_out)) & ~(8'h01 << $past(bus_wdata[3:1]))) == 8'h00));

    // R6 / R10: with no committed write, latches and enables hold
    assert_hold_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                    $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

    // R11: a port A data write appears on the latch after the edge
    assert_write_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == 2'd0) |=> pa_out == $past(bus_wdata));

    // R7: an input port A read returns the live pins
    assert_read_live_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == 2'd0 && pa_oe == 8'h00) |-> bus_rdata == pa_in);

    // R7: an input port B read returns the live pins
    assert_read_live_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == 2'd1 && pb_oe == 8'h00) |-> bus_rdata == pb_in);

    // R9: port C read mixes latch and pins per half
    assert_read_mix_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_addr == 2'd2) |->
            bus_rdata == ((pc_out & pc_oe) | (pc_in & ~pc_oe)));

    // R3: enables inside each direction group agree
    assert_group_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF) &&
        (pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF) &&
        (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF));

    // R10: no read data outside a read
    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_oe |-> bus_rdata == 8'h00);
endmodule

bind pport_unit pport_unit_checker u_chk (.*);

// File: tb/pport_unit_bench.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random accesses against a model.
module pport_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rdata_oe;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [7:0] m_a, m_b, m_c;
    logic       m_ain, m_bin, m_cuin, m_clin;

    always #2.5 clk = ~clk;

    pport_unit u_pport_unit (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] oe_of(input logic is_in);
        return is_in ? 8'h00 : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_ain ? pa_in : m_a;
            2'd1: return m_bin ? pb_in : m_b;
            2'd2: return {m_cuin ? pc_in[7:4] : m_c[7:4], m_clin ? pc_in[3:0] : m_c[3:0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_a = 0; m_b = 0; m_c = 0;
        m_ain = 1; m_bin = 1; m_cuin = 1; m_clin = 1;
    endtask

    // Compare all port-side outputs with the model
    task automatic check_pins(input string req);
        check(req, pa_out, m_a);
        check(req, pb_out, m_b);
        check(req, pc_out, m_c);
        check(req, pa_oe, oe_of(m_ain));
        check(req, pb_oe, oe_of(m_bin));
        check(req, {pc_oe[7:4], pc_oe[3:0]}, {oe_of(m_cuin)[7:4], oe_of(m_clin)[3:0]});
    endtask

    // One-cycle write, driven at the falling edge; sel=0 models an unselected strobe
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic s);
        @(negedge clk);
        bus_sel = s; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (s) begin
            case (a)
                2'd0: m_a = d;
                2'd1: m_b = d;
                2'd2: m_c = d;
                default: begin
                    if (d[7]) begin
                        m_ain = d[4]; m_cuin = d[3]; m_bin = d[1]; m_clin = d[0];
                        m_a = 0; m_b = 0; m_c = 0;
                    end else begin
                        m_c[d[3:1]] = d[0];
                    end
                end
            endcase
        end
    endtask

    // Combinational read, sampled mid-cycle
    task automatic bus_read(input logic [1:0] a, input string req);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1;
        check(req, bus_rdata_oe, 1'b1);
        check(req, bus_rdata, exp_read(a));
        bus_sel = 0; bus_rd = 0;
        #0.5;
        check("R10", {bus_rdata_oe, bus_rdata}, 9'h000);
    endtask

    function automatic logic [7:0] mode_word(input logic [3:0] dirs);
        return {1'b1, 2'b00, dirs[3], dirs[2], 1'b0, dirs[1], dirs[0]};
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        check_pins("R1");
        check("R1", bus_rdata_oe, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check_pins("R1");

        // R3: A output, B input, C upper input, C lower output
        bus_write(2'd3, mode_word(4'b0110), 1);
        check_pins("R3");
        // R2 / R11: data writes reach only the addressed port
        bus_write(2'd0, 8'hA5, 1);
        check_pins("R11");
        bus_write(2'd2, 8'h3C, 1);
        check_pins("R2");
        bus_write(2'd1, 8'h77, 1);
        check("R2", pb_oe, 8'h00);
        check_pins("R2");
        pa_in = 8'h11; pb_in = 8'h99; pc_in = 8'hE7;
        bus_read(2'd0, "R8");
        bus_read(2'd1, "R7");
        bus_read(2'd2, "R9");
        bus_read(2'd3, "R2");
        // R5: set bit 7 and clear bit 2, others untouched
        bus_write(2'd3, 8'h0F, 1);
        check_pins("R5");
        bus_write(2'd3, 8'h04, 1);
        check_pins("R5");
        // R10: unselected write changes nothing
        bus_write(2'd0, 8'h00, 0);
        bus_write(2'd3, 8'h80, 0);
        check_pins("R10");
        // R6: hold over idle cycles
        repeat (5) @(negedge clk);
        check_pins("R6");
        // R4: mode definition clears latches even when all outputs
        bus_write(2'd3, mode_word(4'b0000), 1);
        check_pins("R4");
        // R9: opposite half split
        bus_write(2'd3, mode_word(4'b0001), 1);
        bus_write(2'd2, 8'h5A, 1);
        pc_in = 8'hC3;
        bus_read(2'd2, "R9");

        // Random phase
        for (int i = 0; i < 400; i++) begin
            int kind;
            kind = $urandom_range(0, 4);
            @(negedge clk);
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            case (kind)
                0: bus_write(2'($urandom_range(0, 2)), 8'($urandom), 1);
                1: bus_write(2'd3, mode_word(4'($urandom)), 1);
                2: bus_write(2'd3, {4'h0, 4'($urandom)}, 1);
                3: bus_write(2'($urandom), 8'($urandom), 0);
                default: bus_read(2'($urandom), "R9");
            endcase
            check_pins("R6");
        end
        finish_run();
    end
endmodule